// File: doc/BRIEF.md
# Two-Phase Rendezvous Pipeline Controller

This block steers a chain of data registers with no shared notion of "when": each stage moves a word forward only after agreeing with its two neighbours, through a hold-state rendezvous cell (a Muller C-element). Requests and acknowledges use transition signalling. A change of level means "event", and the level itself carries no meaning. A producer places a word on `in_data` and flips `in_req`. The controller flips `in_ack` once the first stage has taken the word. Words then ripple toward the consumer, which sees `out_req` differ from its own `out_ack`, takes `out_data`, and flips `out_ack`.

For synthesis and checking, the chain is written as a clocked emulation: every rendezvous cell is evaluated once per clock edge. When a cell's output flips, it raises a one-cycle load pulse for its stage register, and that register captures the word held by the stage upstream. A stage counts as full when its cell output differs from the cell output downstream. After reset every stage is empty. With a stalled consumer the chain holds one word per stage.

Top module: `mp_pipe_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every cell output is low, so `in_ack` = 0, `out_req` = 0 and `out_data` = 0.
- R2: Each cell takes two inputs: the upstream cell's output (`in_req` for the first cell) and the inverted output of the downstream cell (`out_ack` for the last cell). When both inputs are 1 or both are 0, the cell's output takes that value at the next edge. Otherwise the output holds.
- R3: A producer may flip `in_req` only while `in_req` equals `in_ack`. If the first stage's successor is empty, `in_ack` flips to match at the first clock edge after the flip.
- R4: A stage advances only when the stage before it holds a word and the stage after it is empty, so two neighbouring stages never load at the same edge. In an empty pipeline of NSTAGE stages, `out_req` flips at the NSTAGE-th edge after an `in_req` flip.
- R5: A stage register loads the upstream word only at the edge where its own cell flips, and holds otherwise. `out_data` stays stable while the consumer stalls.
- R6: With `out_ack` held still, the pipeline accepts exactly NSTAGE words. A further request stays pending, with `in_ack` different from `in_req`.
- R7: The consumer takes the word on `out_data` while `out_req` differs from `out_ack`, and flips `out_ack` only then. Words leave in the order they entered, with none lost and none repeated, under any pattern of producer gaps and consumer stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock; each cell is evaluated once per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | 1 | Producer request; each flip offers a new word |
| in_data | input | WIDTH | Word offered by the producer |
| in_ack | output | 1 | First cell's output; flips when the first stage has taken the word |
| out_req | output | 1 | Last cell's output; differs from out_ack while a word waits |
| out_data | output | WIDTH | Word held by the last stage |
| out_ack | input | 1 | Consumer acknowledge; each flip releases the last stage |

## Verification
On every cycle, the embedded properties check the rendezvous rule in each cell (set on agreement, hold on disagreement), that each stage register loads and holds in step with its cell, that neighbouring stages never load together, and that both environment sides flip their handshake line only when allowed. The bench scenarios are the only way to show end-to-end behaviour: the exact latency through an empty chain, a capacity of exactly NSTAGE words behind a stalled consumer, and in-order delivery without loss or repetition. Those scenarios are swept over several producer gap and consumer stall levels.

// File: rtl/mp_pkg.sv
package mp_pkg;

    // State held by one rendezvous cell
    typedef struct packed {
        logic ctl;
    } cell_state_t;

    // Hold-state rendezvous: follow the inputs when they agree, else keep
    function automatic logic rendezvous(input logic a, input logic b, input logic prev);
        return (a == b) ? a : prev;
    endfunction

endpackage

// File: rtl/mp_celem_cell.sv
module mp_celem_cell
    import mp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_i,
    input  logic dn_i,
    output logic ctl_o,
    output logic load_o
);

    logic        in_a;
    logic        in_b;
    cell_state_t st_d;
    cell_state_t st_q;

    assign in_a = up_i;
    assign in_b = ~dn_i;

    always_comb begin
        st_d     = st_q;
        st_d.ctl = rendezvous(in_a, in_b, st_q.ctl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o  = st_q.ctl;
    assign load_o = st_d.ctl ^ st_q.ctl;

    // R2: agreeing inputs drive the output to their common value
    assert_agree_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_a == in_b) |=> (ctl_o == $past(in_a)));

    // R2: disagreeing inputs leave the output unchanged
    assert_differ_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_a != in_b) |=> $stable(ctl_o));

endmodule

// File: rtl/mp_stage_reg.sv
module mp_stage_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] word_i,
    output logic [WIDTH-1:0] word_o
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } stage_state_t;

    stage_state_t st_d;
    stage_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.word = word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;

    // R5: a load pulse captures the upstream word at that edge
    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (word_o == $past(word_i)));

    // R5: without a load pulse the stored word is kept
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(word_o));

endmodule

// File: rtl/mp_pipe_ctrl.sv
module mp_pipe_ctrl #(
    parameter int NSTAGE = 4,
    parameter int WIDTH  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_req,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ack,
    output logic             out_req,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_ack
);

    localparam int LAST = NSTAGE - 1;

    logic [NSTAGE-1:0]             ctl;
    logic [NSTAGE-1:0]             load;
    logic [NSTAGE-1:0]             up_vec;
    logic [NSTAGE-1:0]             dn_vec;
    logic [NSTAGE:0][WIDTH-1:0]    word_vec;

    // upstream of cell i: producer or cell i-1; downstream: cell i+1 or consumer
    assign up_vec      = {ctl[NSTAGE-2:0], in_req};
    assign dn_vec      = {out_ack, ctl[NSTAGE-1:1]};
    assign word_vec[0] = in_data;

    for (genvar gi = 0; gi < NSTAGE; gi++) begin : g_stage
        mp_celem_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .up_i   (up_vec[gi]),
            .dn_i   (dn_vec[gi]),
            .ctl_o  (ctl[gi]),
            .load_o (load[gi])
        );

        mp_stage_reg #(.WIDTH(WIDTH)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load[gi]),
            .word_i (word_vec[gi]),
            .word_o (word_vec[gi+1])
        );

        if (gi < LAST) begin : g_pair
            // R4: neighbouring stages never load on the same edge
            assert_no_adjacent_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !(load[gi] && load[gi+1]));
        end
    end

    assign in_ack   = ctl[0];
    assign out_req  = ctl[LAST];
    assign out_data = word_vec[NSTAGE];

    // R3: the producer flips its request only when the previous one was taken
    assert_req_toggle_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_req) |-> (in_req != in_ack));

    // R7: the consumer flips its acknowledge only to take a waiting word
    assert_ack_toggle_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_ack) |-> (out_ack == out_req));

endmodule

// File: tb/sim_mp_pipe_ctrl.sv
module sim_mp_pipe_ctrl;

    localparam int  N          = 4;
    localparam int  W          = 8;
    localparam time CLK_PERIOD = 10;

    logic         clk;
    logic         rst_n;
    logic         in_req;
    logic [W-1:0] in_data;
    logic         in_ack;
    logic         out_req;
    logic [W-1:0] out_data;
    logic         out_ack;

    int checks;
    int errors;

    mp_pipe_ctrl #(.NSTAGE(N), .WIDTH(W)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_req   (in_req),
        .in_data  (in_data),
        .in_ack   (in_ack),
        .out_req  (out_req),
        .out_data (out_data),
        .out_ack  (out_ack)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [W-1:0] word_of(input int k);
        return W'(k * 37 + 11);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Offer word k once the previous request has been taken (R3)
    task automatic push(input int k);
        while (in_req != in_ack) @(negedge clk);
        in_data = word_of(k);
        in_req  = ~in_req;
    endtask

    // Take the waiting word and compare against word k (R7)
    task automatic pop(input int k);
        while (out_req == out_ack) @(negedge clk);
        check(out_data == word_of(k), "R7", "word order", int'(out_data), int'(word_of(k)));
        out_ack = ~out_ack;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: cycles got %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        checks  = 0;
        errors  = 0;
        rst_n   = 1'b0;
        in_req  = 1'b0;
        in_data = '0;
        out_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(in_ack == 1'b0, "R1", "in_ack after reset", int'(in_ack), 0);
        check(out_req == 1'b0, "R1", "out_req after reset", int'(out_req), 0);
        check(out_data == '0, "R1", "out_data after reset", int'(out_data), 0);

        // R3 / R4: latency of one word through an empty chain
        @(negedge clk);
        push(0);
        @(negedge clk);
        check(in_ack == 1'b1, "R3", "in_ack one edge after request", int'(in_ack), 1);
        repeat (N - 2) @(negedge clk);
        check(out_req == 1'b0, "R4", "out_req before NSTAGE edges", int'(out_req), 0);
        @(negedge clk);
        check(out_req == 1'b1, "R4", "out_req after NSTAGE edges", int'(out_req), 1);
        check(out_data == word_of(0), "R5", "first word delivered", int'(out_data), int'(word_of(0)));

        // R5: consumer stalled, output word stays
        repeat (5) @(negedge clk);
        check(out_data == word_of(0), "R5", "out_data held in stall", int'(out_data), int'(word_of(0)));

        // R2: both inputs of cell 0 low again -> output returns low
        push(1);
        @(negedge clk);
        check(in_ack == 1'b0, "R2", "first cell follows agreeing low inputs", int'(in_ack), 0);

        // R6: capacity with stalled consumer
        push(2);
        push(3);
        repeat (4 * N) @(negedge clk);
        check(in_ack == in_req, "R6", "NSTAGE-th word accepted", int'(in_ack), int'(in_req));
        push(4);
        repeat (4 * N) @(negedge clk);
        check(in_ack != in_req, "R6", "extra word left pending", int'(in_ack), int'(~in_req));
        check(out_data == word_of(0), "R5", "out_data held while full", int'(out_data), int'(word_of(0)));

        // R7: drain in order, then nothing more appears
        for (int k = 0; k < N + 1; k++) begin
            pop(k);
            @(negedge clk);
        end
        repeat (3 * N) @(negedge clk);
        check(out_req == out_ack, "R7", "no repeated word after drain", int'(out_req), int'(out_ack));
        check(in_ack == in_req, "R3", "pending request taken after drain", int'(in_ack), int'(in_req));

        // R7: sweep producer gaps and consumer stalls
        for (int s = 0; s < 4; s++) begin
            automatic int base = 100 + s * 100;
            fork
                begin
                    for (int k = 0; k < 100; k++) begin
                        repeat ($urandom_range(s, 0)) @(negedge clk);
                        push(base + k);
                        @(negedge clk);
                    end
                end
                begin
                    for (int k = 0; k < 100; k++) begin
                        repeat ($urandom_range(2 * s, 0)) @(negedge clk);
                        pop(base + k);
                        @(negedge clk);
                    end
                end
            join
            repeat (3 * N) @(negedge clk);
            check(out_req == out_ack, "R7", "no extra word after sweep", int'(out_req), int'(out_ack));
            check(in_ack == in_req, "R7", "no lost request after sweep", int'(in_ack), int'(in_req));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule